// File: doc/BRIEF.md
# Multi-Cycle Subset Processor Core

This block is a 32-bit processor core that runs each instruction over several clock cycles and uses one ALU for every arithmetic step: the PC increment, the branch target, the operation itself and the load/store address. Instructions and data share a single word-organised memory inside the block. Around that memory sit the register file, the program counter, the instruction register and holding registers for the operands, the ALU result, the branch target and loaded data.

Every instruction is decoded from its 6-bit opcode alone. Register-register operations carry no function field. Three formats are used. The register form names two sources and a destination. The immediate form names a source, a target and a 16-bit immediate. The jump form carries a 26-bit word address.

An init port reaches the memory through a multiplexer. While the init enable is high, the core is held in reset and a testbench writes the program image word by word. Execution starts at address 0 once the enable drops. Debug outputs show the PC, the current instruction, a fetch-cycle flag and each register write.

Top module: `mc_core`

## Requirements
- R1: The opcode sits in instruction bits 31:26. Codes: 0 no-op, 1 add, 2 sub, 3 and, 4 or, 5 slt, 6 lw, 7 sw, 8 beq, 9 bne, 10 addi, 11 andi, 12 ori, 13 slti, 14 j. First source is bits 25:21, second source/target is bits 20:16, register destination is bits 15:11. The immediate is 15:0 and the jump address is 25:0. In the register form, bits 10:0 have no effect.
- R2: add, sub, and, or and slt (signed compare, result 1 or 0) write rd. They take 4 cycles: fetch, decode, execute, write-back.
- R3: addi and slti use the sign-extended immediate. andi and ori use the zero-extended immediate. All four write rt and take 4 cycles.
- R4: lw reads the word at rs + sign-extended offset into rt and takes 5 cycles. sw stores rt at that address, takes 4 cycles and writes no register.
- R5: beq (taken when the sources are equal) and bne (taken when they differ) jump to PC+4 + (sign-extended offset << 2). Otherwise they go to PC+4. Both take 3 cycles.
- R6: j goes to {PC+4 bits 31:28, address, 2'b00} and takes 3 cycles.
- R7: The no-op and every opcode from 15 to 63 take 3 cycles and write neither a register nor memory.
- R8: Register 0 reads as zero. A write aimed at it is dropped, and dbg_rf_we_o stays low for it.
- R9: The PC resets to 0 and stays word-aligned. dbg_fetch_o is high exactly in the fetch cycle, and dbg_pc_o then shows the fetch address. From the next cycle until the instruction completes, dbg_pc_o shows PC+4, which wraps modulo 2^32.
- R10: Memory is indexed by byte-address bits [MEM_AW+1:2], and higher bits are ignored. Instruction fetch and data access share the one array.
- R11: While init_en_i is high, the core is held. From the first edge on, dbg_pc_o and dbg_instr_o read 0 and no register is written. All registers are cleared. init_data_i is written to word init_addr_i on each edge with init_we_i high. The first fetch, from address 0, is in the cycle in which init_en_i is low.
- R12: dbg_instr_o holds the instruction fetched, from the cycle after its fetch to the next fetch. dbg_rf_we_o, dbg_rf_waddr_o and dbg_rf_wdata_o report the register write in the write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_en_i | input | 1 | Hold core and route memory to the init port |
| init_we_i | input | 1 | Init write strobe |
| init_addr_i | input | MEM_AW (8) | Init word index |
| init_data_i | input | 32 | Init write data |
| dbg_pc_o | output | 32 | Program counter register |
| dbg_instr_o | output | 32 | Instruction register |
| dbg_fetch_o | output | 1 | High in the fetch cycle |
| dbg_rf_we_o | output | 1 | Register file write strobe |
| dbg_rf_waddr_o | output | 5 | Register written |
| dbg_rf_wdata_o | output | 32 | Value written |

## Verification
The hardest case to reach is a PC whose upper four bits are not zero. A jump must keep those bits, and the memory index must drop them. Neither shows up while a program runs upward from address 0. The stimulus gets there with a backward branch taken past address zero, which wraps the PC to the top of the address space. The instruction placed at the aliased word is a jump, so the jump-target rule is exercised with PC+4 bits 31:28 equal to 0xF. Loads and stores with large and negative offsets that land on the same word cover the address aliasing. Finally, the init port is raised in the middle of an instruction. After the program is reloaded, a register written earlier must read zero.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  typedef enum logic [5:0] {
    OP_NOP = 6'd0, OP_ADD = 6'd1, OP_SUB = 6'd2, OP_AND = 6'd3, OP_OR = 6'd4,
    OP_SLT = 6'd5, OP_LW = 6'd6, OP_SW = 6'd7, OP_BEQ = 6'd8, OP_BNE = 6'd9,
    OP_ADDI = 6'd10, OP_ANDI = 6'd11, OP_ORI = 6'd12, OP_SLTI = 6'd13, OP_J = 6'd14
  } opcode_e;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} state_e;
  typedef enum logic [2:0] {CL_NOP, CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_JMP} cls_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [2:0] {B_FOUR, B_REG, B_SEXT, B_ZEXT, B_BOFS} bsel_e;
  typedef enum logic [1:0] {PC_ALU, PC_TGT, PC_JMP} pcsel_e;

  typedef struct packed {
    logic    ir_we, pc_we, ab_we, tgt_we, out_we, mdr_we, mem_we, rf_we;
    logic    a_pc, addr_alu, rf_dst_rd, rf_from_mdr;
    pcsel_e  pc_sel;
    bsel_e   b_sel;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile import mc_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  output logic [XLEN-1:0]   rdata_a_o,
  output logic [XLEN-1:0]   rdata_b_o,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [XLEN-1:0]   wdata_i
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           regs_q[g] <= '0;
      else if (clr_i)                                        regs_q[g] <= '0;
      else if (we_i && (g != 0) && waddr_i == REG_AW'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign rdata_b_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic [5:0] opcode_i,
  input  logic       zero_i,
  output state_e     state_o,
  output ctrl_t      ctrl_o
);
  state_e  state_q, state_d;
  cls_e    cls;
  alu_op_e exec_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_FETCH;
    else if (hold_i) state_q <= ST_FETCH;
    else             state_q <= state_d;
  end

  always_comb begin
    cls     = CL_NOP;
    exec_op = ALU_ADD;
    case (opcode_i)
      OP_ADD:  begin cls = CL_RR; exec_op = ALU_ADD; end
      OP_SUB:  begin cls = CL_RR; exec_op = ALU_SUB; end
      OP_AND:  begin cls = CL_RR; exec_op = ALU_AND; end
      OP_OR:   begin cls = CL_RR; exec_op = ALU_OR;  end
      OP_SLT:  begin cls = CL_RR; exec_op = ALU_SLT; end
      OP_ADDI: begin cls = CL_RI; exec_op = ALU_ADD; end
      OP_ANDI: begin cls = CL_RI; exec_op = ALU_AND; end
      OP_ORI:  begin cls = CL_RI; exec_op = ALU_OR;  end
      OP_SLTI: begin cls = CL_RI; exec_op = ALU_SLT; end
      OP_LW:   cls = CL_LD;
      OP_SW:   cls = CL_ST;
      OP_BEQ, OP_BNE: begin cls = CL_BR; exec_op = ALU_SUB; end
      OP_J:    cls = CL_JMP;
      default: cls = CL_NOP;
    endcase
  end

  always_comb begin
    ctrl_o  = '0;
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH: begin
        ctrl_o.ir_we = 1'b1; ctrl_o.a_pc = 1'b1; ctrl_o.b_sel = B_FOUR;
        ctrl_o.pc_we = 1'b1; ctrl_o.pc_sel = PC_ALU;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.ab_we = 1'b1; ctrl_o.tgt_we = 1'b1;
        ctrl_o.a_pc  = 1'b1; ctrl_o.b_sel = B_BOFS;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl_o.alu_op = exec_op;
        case (cls)
          CL_RR: begin ctrl_o.b_sel = B_REG; ctrl_o.out_we = 1'b1; state_d = ST_WB; end
          CL_RI: begin
            ctrl_o.b_sel  = (opcode_i == OP_ANDI || opcode_i == OP_ORI) ? B_ZEXT : B_SEXT;
            ctrl_o.out_we = 1'b1; state_d = ST_WB;
          end
          CL_LD, CL_ST: begin ctrl_o.b_sel = B_SEXT; ctrl_o.out_we = 1'b1; state_d = ST_MEM; end
          CL_BR: begin
            ctrl_o.b_sel  = B_REG; ctrl_o.pc_sel = PC_TGT;
            ctrl_o.pc_we  = (opcode_i == OP_BNE) ? !zero_i : zero_i;
          end
          CL_JMP: begin ctrl_o.pc_we = 1'b1; ctrl_o.pc_sel = PC_JMP; end
          default: ;
        endcase
      end
      ST_MEM: begin
        ctrl_o.addr_alu = 1'b1;
        if (cls == CL_LD) begin ctrl_o.mdr_we = 1'b1; state_d = ST_WB; end
        else ctrl_o.mem_we = 1'b1;
      end
      ST_WB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_dst_rd   = (cls == CL_RR);
        ctrl_o.rf_from_mdr = (cls == CL_LD);
      end
      default: ;
    endcase
    if (hold_i) ctrl_o = '0;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter  int MEM_WORDS = 256,
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_en_i,
  input  logic              init_we_i,
  input  logic [MEM_AW-1:0] init_addr_i,
  input  logic [31:0]       init_data_i,
  output logic [31:0]       dbg_pc_o,
  output logic [31:0]       dbg_instr_o,
  output logic              dbg_fetch_o,
  output logic              dbg_rf_we_o,
  output logic [4:0]        dbg_rf_waddr_o,
  output logic [31:0]       dbg_rf_wdata_o
);
  ctrl_t           c;
  state_e          state;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, tgt_q, out_q, mdr_q;
  logic [XLEN-1:0] rs_val, rt_val, alu_a, alu_b, alu_y, pc_d, sext, zext, core_addr;
  logic [XLEN-1:0] mem_rdata, mem_wdata;
  logic [MEM_AW-1:0] mem_addr;
  logic            alu_zero, mem_we, rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  mc_ctrl u_ctrl (
    .clk_i, .rst_ni, .hold_i(init_en_i), .opcode_i(ir_q[31:26]),
    .zero_i(alu_zero), .state_o(state), .ctrl_o(c)
  );

  assign sext = {{16{ir_q[15]}}, ir_q[15:0]};
  assign zext = {16'b0, ir_q[15:0]};

  always_comb begin
    alu_a = c.a_pc ? pc_q : a_q;
    unique case (c.b_sel)
      B_REG:   alu_b = b_q;
      B_SEXT:  alu_b = sext;
      B_ZEXT:  alu_b = zext;
      B_BOFS:  alu_b = {sext[XLEN-3:0], 2'b00};
      default: alu_b = 32'd4;
    endcase
    unique case (c.pc_sel)
      PC_TGT:  pc_d = tgt_q;
      PC_JMP:  pc_d = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_d = alu_y;
    endcase
  end

  mc_alu u_alu (.a_i(alu_a), .b_i(alu_b), .op_i(c.alu_op), .y_o(alu_y), .zero_o(alu_zero));

  assign rf_waddr = c.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = c.rf_from_mdr ? mdr_q : out_q;
  assign rf_we    = c.rf_we && (rf_waddr != '0);

  mc_regfile u_rf (
    .clk_i, .rst_ni, .clr_i(init_en_i),
    .ra_i(ir_q[25:21]), .rb_i(ir_q[20:16]), .rdata_a_o(rs_val), .rdata_b_o(rt_val),
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata)
  );

  // init port owns the memory while the core is held
  assign core_addr = c.addr_alu ? out_q : pc_q;
  assign mem_addr  = init_en_i ? init_addr_i : MEM_AW'(core_addr >> 2);
  assign mem_wdata = init_en_i ? init_data_i : b_q;
  assign mem_we    = init_en_i ? init_we_i   : c.mem_we;

  mc_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk_i, .we_i(mem_we), .addr_i(mem_addr), .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; ir_q <= '0;
    end else if (init_en_i) begin
      pc_q <= '0; ir_q <= '0;
    end else begin
      if (c.pc_we) pc_q <= pc_d;
      if (c.ir_we) ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; tgt_q <= '0; out_q <= '0; mdr_q <= '0;
    end else begin
      if (c.ab_we)  begin a_q <= rs_val; b_q <= rt_val; end
      if (c.tgt_we) tgt_q <= alu_y;
      if (c.out_we) out_q <= alu_y;
      if (c.mdr_we) mdr_q <= mem_rdata;
    end
  end

  assign dbg_pc_o       = pc_q;
  assign dbg_instr_o    = ir_q;
  assign dbg_fetch_o    = (state == ST_FETCH);
  assign dbg_rf_we_o    = rf_we;
  assign dbg_rf_waddr_o = rf_waddr;
  assign dbg_rf_wdata_o = rf_wdata;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_en_i,
  input logic [31:0] dbg_pc_o,
  input logic [31:0] dbg_instr_o,
  input logic        dbg_fetch_o,
  input logic        dbg_rf_we_o,
  input logic [4:0]  dbg_rf_waddr_o
);
  p_no_zero_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rf_we_o |-> dbg_rf_waddr_o != 5'd0);

  p_hold_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_en_i |=> (dbg_pc_o == 32'd0 && dbg_instr_o == 32'd0));

  p_hold_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_en_i |-> !dbg_rf_we_o);

  p_pc_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_pc_o[1:0] == 2'b00);

  p_fetch_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_fetch_o && !init_en_i) |=> (!dbg_fetch_o && dbg_pc_o == $past(dbg_pc_o) + 32'd4));

  p_instr_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_fetch_o && !init_en_i) |=> $stable(dbg_instr_o));

  p_wb_ends_instr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rf_we_o && !init_en_i) |=> dbg_fetch_o);
endmodule

bind mc_core mc_core_chk u_chk (.*);

// File: tb/tb_mc_core.sv
module tb_mc_core;
  localparam int MEM_WORDS = 256;
  localparam int MEM_AW    = $clog2(MEM_WORDS);
  localparam int WD_CYCLES = 20000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic init_en_i = 1'b1, init_we_i = 1'b0;
  logic [MEM_AW-1:0] init_addr_i = '0;
  logic [31:0] init_data_i = '0;
  logic [31:0] dbg_pc_o, dbg_instr_o, dbg_rf_wdata_o;
  logic dbg_fetch_o, dbg_rf_we_o;
  logic [4:0] dbg_rf_waddr_o;

  always #10 clk_i = ~clk_i;

  mc_core #(.MEM_WORDS(MEM_WORDS)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] img   [MEM_WORDS];
  logic [31:0] m_mem [MEM_WORDS];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc, m_ir;
  int cyc = 0;
  string prev_tag = "R11";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc_r(int op, int rs, int rt, int rd);
    return {6'(op), 5'(rs), 5'(rt), 5'(rd), 11'h5a5};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int addr);
    return {6'(op), 26'(addr)};
  endfunction
  function automatic int idx(logic [31:0] a);
    return int'(a[MEM_AW+1:2]);
  endfunction
  function automatic int lat(logic [5:0] op);
    if (op == 6) return 5;
    if ((op >= 1 && op <= 5) || op == 7 || (op >= 10 && op <= 13)) return 4;
    return 3;
  endfunction
  function automatic string tag_of(logic [5:0] op);
    if (op >= 1 && op <= 5)   return "R2";
    if (op >= 10 && op <= 13) return "R3";
    if (op == 6 || op == 7)   return "R4 R10";
    if (op == 8 || op == 9)   return "R5";
    if (op == 14)             return "R6";
    return "R7";
  endfunction

  // behavioural effect of the current model instruction
  task automatic eval(output bit wr, output logic [4:0] dst, output logic [31:0] val,
                      output logic [31:0] npc, output bit st, output logic [31:0] ea);
    logic [5:0] op;
    logic [31:0] rs, rt, sx, zx, pc4;
    op = m_ir[31:26];
    rs = m_reg[m_ir[25:21]]; rt = m_reg[m_ir[20:16]];
    sx = {{16{m_ir[15]}}, m_ir[15:0]}; zx = {16'b0, m_ir[15:0]};
    pc4 = m_pc + 32'd4;
    wr = 1'b0; st = 1'b0; dst = m_ir[20:16]; val = '0; npc = pc4; ea = rs + sx;
    case (op)
      6'd1: begin wr = 1; dst = m_ir[15:11]; val = rs + rt; end
      6'd2: begin wr = 1; dst = m_ir[15:11]; val = rs - rt; end
      6'd3: begin wr = 1; dst = m_ir[15:11]; val = rs & rt; end
      6'd4: begin wr = 1; dst = m_ir[15:11]; val = rs | rt; end
      6'd5: begin wr = 1; dst = m_ir[15:11]; val = ($signed(rs) < $signed(rt)) ? 1 : 0; end
      6'd6: begin wr = 1; val = m_mem[idx(ea)]; end
      6'd7: st = 1;
      6'd8: if (rs == rt) npc = pc4 + (sx << 2);
      6'd9: if (rs != rt) npc = pc4 + (sx << 2);
      6'd10: begin wr = 1; val = rs + sx; end
      6'd11: begin wr = 1; val = rs & zx; end
      6'd12: begin wr = 1; val = rs | zx; end
      6'd13: begin wr = 1; val = ($signed(rs) < $signed(sx)) ? 1 : 0; end
      6'd14: npc = {pc4[31:28], m_ir[25:0], 2'b00};
      default: ;
    endcase
  endtask

  task automatic step();
    bit wr, st, exp_we;
    logic [4:0] dst;
    logic [31:0] val, npc, ea;
    int l;
    string t;
    if (cyc == 0) m_ir = m_mem[idx(m_pc)];
    l = lat(m_ir[31:26]);
    t = tag_of(m_ir[31:26]);
    eval(wr, dst, val, npc, st, ea);
    chk(dbg_fetch_o == (cyc == 0), t, 32'(dbg_fetch_o), 32'(cyc == 0));
    if (cyc == 0) chk(dbg_pc_o == m_pc, prev_tag, dbg_pc_o, m_pc);
    else begin
      chk(dbg_pc_o == m_pc + 32'd4, "R9", dbg_pc_o, m_pc + 32'd4);
      chk(dbg_instr_o == m_ir, "R12", dbg_instr_o, m_ir);
    end
    exp_we = (cyc == l - 1) && wr && (dst != 0);
    chk(dbg_rf_we_o == exp_we, (wr && dst == 0) ? "R8" : t, 32'(dbg_rf_we_o), 32'(exp_we));
    if (exp_we) begin
      chk(dbg_rf_waddr_o == dst, "R1 R12", 32'(dbg_rf_waddr_o), 32'(dst));
      chk(dbg_rf_wdata_o == val, t, dbg_rf_wdata_o, val);
    end
    if (cyc == l - 1) begin
      if (wr && dst != 0) m_reg[dst] = val;
      if (st) m_mem[idx(ea)] = m_reg[m_ir[20:16]];
      prev_tag = (t == "R5" || t == "R6") ? t : "R9";
      m_pc = npc;
      cyc = 0;
    end else cyc++;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      #1;
      step();
      @(negedge clk_i);
    end
  endtask

  task automatic load();
    init_en_i = 1'b1;
    for (int i = 0; i < MEM_WORDS; i++) begin
      init_we_i = 1'b1; init_addr_i = MEM_AW'(i); init_data_i = img[i];
      @(negedge clk_i);
      chk(dbg_pc_o == 0, "R11", dbg_pc_o, 0);
      chk(dbg_instr_o == 0, "R11", dbg_instr_o, 0);
      chk(!dbg_rf_we_o, "R11", 32'(dbg_rf_we_o), 0);
    end
    init_we_i = 1'b0; init_en_i = 1'b0;
    m_mem = img;
    foreach (m_reg[r]) m_reg[r] = '0;
    m_pc = '0; cyc = 0; prev_tag = "R11";
  endtask

  task automatic prog_a();
    foreach (img[i]) img[i] = '0;
    img[0]  = enc_i(10, 0, 1, 5);
    img[1]  = enc_i(10, 0, 2, -3);
    img[2]  = enc_r(1, 1, 2, 3);
    img[3]  = enc_r(2, 2, 1, 4);
    img[4]  = enc_r(5, 2, 1, 5);
    img[5]  = enc_r(5, 1, 2, 6);
    img[6]  = enc_i(11, 2, 7, 16'hf0f0);
    img[7]  = enc_i(12, 0, 8, 16'h8001);
    img[8]  = enc_i(13, 2, 9, -1);
    img[9]  = enc_r(3, 8, 7, 11);
    img[10] = enc_r(4, 8, 7, 12);
    img[11] = enc_i(10, 1, 0, 7);
    img[12] = enc_r(1, 0, 1, 13);
    img[13] = enc_i(7, 0, 12, 16'h0200);
    img[14] = enc_i(6, 0, 14, 16'h0600);
    img[15] = enc_i(6, 0, 15, 16'hfe00);
    img[16] = enc_i(8, 1, 13, 2);
    img[17] = enc_i(10, 0, 20, 1);
    img[18] = enc_i(10, 0, 21, 1);
    img[19] = enc_i(9, 1, 13, 5);
    img[20] = enc_i(9, 1, 2, 1);
    img[21] = enc_i(10, 0, 22, 1);
    img[22] = 32'h0;
    img[23] = {6'd63, 26'h3ffffff};
    img[24] = enc_i(8, 0, 0, -64);
    img[217] = enc_j(14, 30);
    img[30] = enc_r(1, 1, 1, 16);
    img[31] = enc_i(7, 0, 4, 16'h03f0);
    img[32] = enc_i(6, 0, 17, 16'h03f0);
    img[33] = enc_r(2, 0, 0, 0);
    img[34] = enc_j(14, 40);
    img[40] = enc_i(8, 0, 0, -1);
  endtask

  task automatic prog_b();
    foreach (img[i]) img[i] = '0;
    img[0] = enc_r(1, 5, 0, 1);
    img[1] = enc_i(10, 0, 2, 16'h7fff);
    img[2] = enc_i(10, 2, 3, 1);
    img[3] = enc_r(2, 0, 3, 4);
    img[4] = enc_i(12, 4, 5, 16'hffff);
    img[5] = enc_i(13, 4, 6, 16'h8000);
    img[6] = enc_j(14, 26'h3ffffff);
    img[255] = enc_i(10, 0, 7, 9);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual %0d cycles expected fewer", WD_CYCLES);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    chk(dbg_pc_o == 0, "R9", dbg_pc_o, 0);
    chk(dbg_instr_o == 0, "R9", dbg_instr_o, 0);
    chk(!dbg_rf_we_o, "R9", 32'(dbg_rf_we_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prog_b(); load();
    run(37);
    prog_a(); load();
    run(230);
    prog_b(); load();
    run(120);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule